// File: doc/BRIEF.md
# Graphics Command Sequencer

This block sits behind a processor output port and turns a stream of 16-bit command words into drawing activity. Each word holds a 6-bit operation in bits 15:10 and a 10-bit argument in bits 9:0. A set of commands stages state inside the block: two corner points, a glyph code and, with each draw, a colour byte laid out as rrggbbxx. A second set of commands acts on that staged state.

Single-pixel plots and full-screen wipes are carried out here, on a pixel write port with X/Y addressing. Line and glyph rendering are done by engines outside the block. For these the block presents the staged coordinates, colour and glyph code, raises a one-cycle start strobe and waits for the engine's done strobe.

The issuer talks to the block through a four-phase valid/complete exchange. It places a command and raises valid. The block raises complete when the operation has finished. The issuer then lowers valid, and the block lowers complete.

Top module: `gfx_cmd_front`

## Requirements
- R1: While reset is asserted, and on leaving it, complete is low, no pixel write is issued and neither engine start strobe is high. All staged registers read zero.
- R2: Operations 0, 1, 2 and 3 load argument bits 9:0 into X1, Y1, X2 and Y2 respectively. The four values appear on the engine coordinate outputs from the cycle after acceptance.
- R3: Operation 4 loads argument bits 7:0 into the glyph register, shown on the glyph output.
- R4: Operation 7 issues exactly one pixel write at (X1, Y1), with colour equal to argument bits 7:0, in the cycle after acceptance. Complete rises one cycle later.
- R5: Operation 8 writes colour 0 to every pixel of an H_RES by V_RES frame. It writes one pixel per cycle, in row-major order from (0,0), starting the cycle after acceptance. Complete rises on the edge that ends the last write.
- R6: Operation 6 latches argument bits 7:0 as the engine colour and raises line start for exactly one cycle after acceptance. Complete rises on the edge where line done is sampled high while the block waits for it.
- R7: Operation 5 does the same as R6 with the glyph engine: glyph start and glyph done.
- R8: Complete, once high, stays high while valid is high. It falls on the first clock edge that samples valid low.
- R9: A command is accepted only on a clock edge where valid is high, was low on the previous edge, and complete is low. Holding valid high after completion neither repeats the operation nor issues writes.
- R10: Operations 9 to 63 raise complete one cycle after acceptance. They issue no write and no start, and leave all staged registers unchanged.
- R11: A done strobe from either engine while the block is not waiting for that engine has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 16 | Command word: operation 15:10, argument 9:0 |
| cmd_valid_i | input | 1 | Issuer's valid level |
| cmd_done_o | output | 1 | Complete level |
| pix_we_o | output | 1 | Pixel write enable |
| pix_x_o | output | 10 | Pixel write column |
| pix_y_o | output | 10 | Pixel write row |
| pix_color_o | output | 8 | Pixel write colour (rrggbbxx) |
| eng_x1_o | output | 10 | Staged X1 |
| eng_y1_o | output | 10 | Staged Y1 |
| eng_x2_o | output | 10 | Staged X2 |
| eng_y2_o | output | 10 | Staged Y2 |
| eng_color_o | output | 8 | Staged draw colour |
| glyph_o | output | 8 | Staged glyph code |
| line_start_o | output | 1 | One-cycle line engine start |
| line_done_i | input | 1 | Line engine finished |
| char_start_o | output | 1 | One-cycle glyph engine start |
| char_done_i | input | 1 | Glyph engine finished |

## Verification
The bench builds the block with H_RES=8 and V_RES=6. This turns the frame wipe into a 48-cycle sweep. At that size every row wrap and the final-pixel completion edge can be compared write by write against a queue of expected pixels. A full 640x480 frame would not fit in the run. Coordinates stay 10 bits wide, so argument values up to 1023 and the full 8-bit colour range are still exercised.

// File: rtl/gfx_pkg.sv
package gfx_pkg;
  localparam int CMD_W   = 16;
  localparam int OP_W    = 6;
  localparam int ARG_W   = CMD_W - OP_W;
  localparam int COLOR_W = 8;
  localparam int GLYPH_W = 8;

  localparam logic [OP_W-1:0] OP_SET_X1    = 6'd0;
  localparam logic [OP_W-1:0] OP_SET_Y1    = 6'd1;
  localparam logic [OP_W-1:0] OP_SET_X2    = 6'd2;
  localparam logic [OP_W-1:0] OP_SET_Y2    = 6'd3;
  localparam logic [OP_W-1:0] OP_SET_GLYPH = 6'd4;
  localparam logic [OP_W-1:0] OP_GLYPH     = 6'd5;
  localparam logic [OP_W-1:0] OP_LINE      = 6'd6;
  localparam logic [OP_W-1:0] OP_PLOT      = 6'd7;
  localparam logic [OP_W-1:0] OP_WIPE      = 6'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLOT, ST_WIPE, ST_LINE_GO, ST_LINE_WAIT, ST_GLYPH_GO, ST_GLYPH_WAIT
  } gfx_state_e;
endpackage

// File: rtl/gfx_rst_sync.sv
module gfx_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/gfx_coord_regs.sv
module gfx_coord_regs #(
  parameter int ARG_W   = 10,
  parameter int GLYPH_W = 8,
  parameter int N_CRD   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en_i,
  input  logic [2:0]                 ld_sel_i,
  input  logic [ARG_W-1:0]           ld_val_i,
  output logic [N_CRD-1:0][ARG_W-1:0] crd_o,
  output logic [GLYPH_W-1:0]         glyph_o
);
  for (genvar i = 0; i < N_CRD; i++) begin : g_crd
    logic [ARG_W-1:0] r_q;
    logic             r_en;
    always_comb r_en = ld_en_i && (ld_sel_i == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= '0;
      else if (r_en) r_q <= ld_val_i;
    end
    assign crd_o[i] = r_q;
  end

  logic glyph_en;
  logic [GLYPH_W-1:0] glyph_q;
  always_comb glyph_en = ld_en_i && (ld_sel_i == 3'(N_CRD));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        glyph_q <= '0;
    else if (glyph_en) glyph_q <= ld_val_i[GLYPH_W-1:0];
  end
  assign glyph_o = glyph_q;
endmodule

// File: rtl/gfx_wipe_sweep.sv
module gfx_wipe_sweep #(
  parameter int H_RES = 640,
  parameter int V_RES = 480,
  parameter int CW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          step_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          last_o
);
  localparam logic [CW-1:0] X_LAST = CW'(H_RES - 1);
  localparam logic [CW-1:0] Y_LAST = CW'(V_RES - 1);

  logic [CW-1:0] x_q, y_q, x_d, y_d;
  logic          row_end;

  always_comb begin
    row_end = (x_q == X_LAST);
    last_o  = row_end && (y_q == Y_LAST);
    x_d = x_q;
    y_d = y_q;
    if (start_i) begin
      x_d = '0;
      y_d = '0;
    end else if (step_i && !last_o) begin
      if (row_end) begin
        x_d = '0;
        y_d = y_q + 1'b1;
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  assert_wipe_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (x_q < CW'(H_RES)) && (y_q < CW'(V_RES)));

  assert_wipe_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && $past(step_i) && !$past(last_o)) |->
      ((x_q == $past(x_q) + 1'b1 && y_q == $past(y_q)) ||
       (x_q == '0 && y_q == $past(y_q) + 1'b1)));
endmodule

// File: rtl/gfx_cmd_front.sv
module gfx_cmd_front
  import gfx_pkg::*;
#(
  parameter int H_RES = 640,
  parameter int V_RES = 480
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic               cmd_valid_i,
  output logic               cmd_done_o,
  output logic               pix_we_o,
  output logic [ARG_W-1:0]   pix_x_o,
  output logic [ARG_W-1:0]   pix_y_o,
  output logic [COLOR_W-1:0] pix_color_o,
  output logic [ARG_W-1:0]   eng_x1_o,
  output logic [ARG_W-1:0]   eng_y1_o,
  output logic [ARG_W-1:0]   eng_x2_o,
  output logic [ARG_W-1:0]   eng_y2_o,
  output logic [COLOR_W-1:0] eng_color_o,
  output logic [GLYPH_W-1:0] glyph_o,
  output logic               line_start_o,
  input  logic               line_done_i,
  output logic               char_start_o,
  input  logic               char_done_i
);
  localparam int N_CRD = 4;

  logic rst_n_s;
  gfx_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  logic [OP_W-1:0]  op;
  logic [ARG_W-1:0] arg;
  assign op  = cmd_i[CMD_W-1:ARG_W];
  assign arg = cmd_i[ARG_W-1:0];

  gfx_state_e st_q, st_d;
  logic valid_q, done_q, done_d, fin;
  logic accept, ld_en, col_en;
  logic [COLOR_W-1:0] col_q;

  always_comb begin
    accept = (st_q == ST_IDLE) && cmd_valid_i && !valid_q && !done_q;
    ld_en  = accept && (op <= OP_SET_GLYPH);
    col_en = accept && (op == OP_GLYPH || op == OP_LINE || op == OP_PLOT);
  end

  logic [N_CRD-1:0][ARG_W-1:0] crd;
  gfx_coord_regs #(.ARG_W(ARG_W), .GLYPH_W(GLYPH_W), .N_CRD(N_CRD)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .ld_en_i(ld_en), .ld_sel_i(op[2:0]),
    .ld_val_i(arg), .crd_o(crd), .glyph_o(glyph_o)
  );

  logic wipe_start, wipe_step, wipe_last;
  logic [ARG_W-1:0] wx, wy;
  assign wipe_start = accept && (op == OP_WIPE);
  assign wipe_step  = (st_q == ST_WIPE);
  gfx_wipe_sweep #(.H_RES(H_RES), .V_RES(V_RES), .CW(ARG_W)) u_sweep (
    .clk(clk), .rst_n(rst_n_s), .start_i(wipe_start), .step_i(wipe_step),
    .x_o(wx), .y_o(wy), .last_o(wipe_last)
  );

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        case (op)
          OP_PLOT:  st_d = ST_PLOT;
          OP_WIPE:  st_d = ST_WIPE;
          OP_LINE:  st_d = ST_LINE_GO;
          OP_GLYPH: st_d = ST_GLYPH_GO;
          default:  fin  = 1'b1;
        endcase
      end
      ST_PLOT:       begin st_d = ST_IDLE; fin = 1'b1; end
      ST_WIPE:       if (wipe_last) begin st_d = ST_IDLE; fin = 1'b1; end
      ST_LINE_GO:    st_d = ST_LINE_WAIT;
      ST_LINE_WAIT:  if (line_done_i) begin st_d = ST_IDLE; fin = 1'b1; end
      ST_GLYPH_GO:   st_d = ST_GLYPH_WAIT;
      ST_GLYPH_WAIT: if (char_done_i) begin st_d = ST_IDLE; fin = 1'b1; end
      default:       st_d = ST_IDLE;
    endcase
    if (fin)                         done_d = 1'b1;
    else if (done_q && !cmd_valid_i) done_d = 1'b0;
    else                             done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q    <= ST_IDLE;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= done_d;
      valid_q <= cmd_valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    col_q <= '0;
    else if (col_en) col_q <= arg[COLOR_W-1:0];
  end

  assign cmd_done_o   = done_q;
  assign pix_we_o     = (st_q == ST_PLOT) || (st_q == ST_WIPE);
  assign pix_x_o      = (st_q == ST_WIPE) ? wx : crd[0];
  assign pix_y_o      = (st_q == ST_WIPE) ? wy : crd[1];
  assign pix_color_o  = (st_q == ST_WIPE) ? '0 : col_q;
  assign eng_x1_o     = crd[0];
  assign eng_y1_o     = crd[1];
  assign eng_x2_o     = crd[2];
  assign eng_y2_o     = crd[3];
  assign eng_color_o  = col_q;
  assign line_start_o = (st_q == ST_LINE_GO);
  assign char_start_o = (st_q == ST_GLYPH_GO);

  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(cmd_done_o) |-> !$past(cmd_valid_i));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_done_o && cmd_valid_i) |=> cmd_done_o);

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({pix_we_o, line_start_o, char_start_o}));

  assert_line_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    line_start_o |=> !line_start_o);

  assert_glyph_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    char_start_o |=> !char_start_o);

  assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && op > OP_WIPE) |=> (cmd_done_o && !pix_we_o && !line_start_o && !char_start_o));

  assert_no_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cmd_done_o && cmd_valid_i) |=> !pix_we_o && !line_start_o && !char_start_o);
endmodule

// File: tb/gfx_cmd_front_tb_top.sv
module gfx_cmd_front_tb_top;
  localparam int H = 8;
  localparam int V = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic        line_done_i = 1'b0;
  logic        char_done_i = 1'b0;
  logic        cmd_done_o, pix_we_o, line_start_o, char_start_o;
  logic [9:0]  pix_x_o, pix_y_o, eng_x1_o, eng_y1_o, eng_x2_o, eng_y2_o;
  logic [7:0]  pix_color_o, eng_color_o, glyph_o;

  always #10 clk = ~clk;

  gfx_cmd_front #(.H_RES(H), .V_RES(V)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .cmd_valid_i(cmd_valid_i),
    .cmd_done_o(cmd_done_o), .pix_we_o(pix_we_o), .pix_x_o(pix_x_o),
    .pix_y_o(pix_y_o), .pix_color_o(pix_color_o), .eng_x1_o(eng_x1_o),
    .eng_y1_o(eng_y1_o), .eng_x2_o(eng_x2_o), .eng_y2_o(eng_y2_o),
    .eng_color_o(eng_color_o), .glyph_o(glyph_o), .line_start_o(line_start_o),
    .line_done_i(line_done_i), .char_start_o(char_start_o), .char_done_i(char_done_i)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit mon_en = 0;
  int wr_seen = 0;

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  // behavioural reference model
  int m_done = 0, m_vprev = 0, m_glyph = 0, m_col = 0, m_eng = 0;
  int m_crd[4] = '{0, 0, 0, 0};
  int qx[$], qy[$], qc[$];
  bit m_wiping = 0;

  always @(posedge clk) begin
    if (mon_en) begin
      int op, arg;
      bit acc, was_done;
      op  = int'(cmd_i[15:10]);
      arg = int'(cmd_i[9:0]);
      was_done = (m_done != 0);
      acc = cmd_valid_i && (m_vprev == 0) && !was_done && qx.size() == 0 && m_eng == 0;
      if (was_done && !cmd_valid_i) m_done = 0;
      if (qx.size() > 0) begin
        void'(qx.pop_front()); void'(qy.pop_front()); void'(qc.pop_front());
        if (qx.size() == 0) begin m_done = 1; m_wiping = 0; end
      end else if (m_eng == 1) m_eng = 2;
      else if (m_eng == 3) m_eng = 4;
      else if (m_eng == 2 && line_done_i) begin m_eng = 0; m_done = 1; end
      else if (m_eng == 4 && char_done_i) begin m_eng = 0; m_done = 1; end
      if (acc) begin
        if (op <= 3) begin m_crd[op] = arg; m_done = 1; end
        else if (op == 4) begin m_glyph = arg % 256; m_done = 1; end
        else if (op == 5) begin m_col = arg % 256; m_eng = 3; end
        else if (op == 6) begin m_col = arg % 256; m_eng = 1; end
        else if (op == 7) begin
          m_col = arg % 256;
          qx.push_back(m_crd[0]); qy.push_back(m_crd[1]); qc.push_back(m_col);
        end else if (op == 8) begin
          m_wiping = 1;
          for (int y = 0; y < V; y++)
            for (int x = 0; x < H; x++) begin
              qx.push_back(x); qy.push_back(y); qc.push_back(0);
            end
        end else m_done = 1;
      end
      m_vprev = cmd_valid_i ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (pix_we_o) wr_seen++;
      chk("R8 done", int'(cmd_done_o), m_done);
      chk(m_wiping ? "R5 we" : "R4 we", int'(pix_we_o), qx.size() > 0 ? 1 : 0);
      if (qx.size() > 0) begin
        chk(m_wiping ? "R5 x" : "R4 x", int'(pix_x_o), qx[0]);
        chk(m_wiping ? "R5 y" : "R4 y", int'(pix_y_o), qy[0]);
        chk(m_wiping ? "R5 colour" : "R4 colour", int'(pix_color_o), qc[0]);
      end
      chk("R6 line_start", int'(line_start_o), m_eng == 1 ? 1 : 0);
      chk("R7 char_start", int'(char_start_o), m_eng == 3 ? 1 : 0);
      chk("R2 x1", int'(eng_x1_o), m_crd[0]);
      chk("R2 y1", int'(eng_y1_o), m_crd[1]);
      chk("R2 x2", int'(eng_x2_o), m_crd[2]);
      chk("R2 y2", int'(eng_y2_o), m_crd[3]);
      chk("R3 glyph", int'(glyph_o), m_glyph);
      chk("R6 colour", int'(eng_color_o), m_col);
    end
  end

  function automatic logic [15:0] mk(input int op, input int arg);
    return {6'(op), 10'(arg)};
  endfunction

  task automatic issue(input int op, input int arg, input int hold);
    @(negedge clk);
    cmd_i = mk(op, arg);
    cmd_valid_i = 1'b1;
    @(negedge clk);
    while (!cmd_done_o) @(negedge clk);
    repeat (hold) @(negedge clk);
    cmd_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic issue_eng(input int op, input int arg, input bit is_line, input int dly);
    @(negedge clk);
    cmd_i = mk(op, arg);
    cmd_valid_i = 1'b1;
    repeat (dly) @(negedge clk);
    if (is_line) line_done_i = 1'b1; else char_done_i = 1'b1;
    @(negedge clk);
    line_done_i = 1'b0;
    char_done_i = 1'b0;
    while (!cmd_done_o) @(negedge clk);
    cmd_valid_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 done", int'(cmd_done_o), 0);
    chk("R1 we", int'(pix_we_o), 0);
    chk("R1 starts", int'(line_start_o | char_start_o), 0);
    chk("R1 x1", int'(eng_x1_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after release", int'(cmd_done_o), 0);
    mon_en = 1;

    // R2 coordinate staging
    issue(0, 5, 0);
    issue(1, 3, 0);
    issue(2, 1023, 0);
    issue(3, 479, 0);
    chk("R2 x2 max", int'(eng_x2_o), 1023);
    // R3 glyph takes low 8 bits
    issue(4, 10'h3C1, 0);
    chk("R3 glyph low byte", int'(glyph_o), 8'hC1);

    // R4 single plot
    base = wr_seen;
    issue(7, 8'hE4, 0);
    chk("R4 one write", wr_seen - base, 1);

    // R9 hold valid after completion: no repeat
    base = wr_seen;
    issue(7, 8'h1C, 6);
    chk("R9 no reissue", wr_seen - base, 1);

    // R5 wipe
    base = wr_seen;
    issue(8, 0, 0);
    chk("R5 wipe writes", wr_seen - base, H * V);

    // R6 line, R7 glyph
    issue_eng(6, 8'h93, 1'b1, 3);
    issue_eng(5, 8'h4B, 1'b0, 5);
    chk("R7 colour", int'(eng_color_o), 8'h4B);

    // R11 stray engine done while idle
    @(negedge clk);
    line_done_i = 1'b1;
    char_done_i = 1'b1;
    @(negedge clk);
    line_done_i = 1'b0;
    char_done_i = 1'b0;
    @(negedge clk);
    chk("R11 done stays low", int'(cmd_done_o), 0);
    chk("R11 no start", int'(line_start_o | char_start_o), 0);

    // R10 unknown operations
    base = wr_seen;
    issue(9, 10'h2AA, 0);
    issue(63, 10'h155, 2);
    chk("R10 no writes", wr_seen - base, 0);
    chk("R10 x1 kept", int'(eng_x1_o), 5);
    chk("R10 glyph kept", int'(glyph_o), 8'hC1);

    // restage and plot again at new point
    issue(0, 7, 0);
    issue(1, 5, 0);
    base = wr_seen;
    issue(7, 8'hFF, 0);
    chk("R4 corner plot", wr_seen - base, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule